// File: doc/BRIEF.md
# Add/Subtract/Compare Unit with Carry Flags

This block is the integer arithmetic slice of a small soft processor datapath. In one
combinational pass it produces a 32-bit sum, a reverse difference (operand B minus
operand A) or an ordering word for a signed or unsigned compare. It also keeps a
status carry bit and a shadow copy of that bit. Both bits are registered and change
only on a clock edge.

For a compare, the result is the difference B minus A. When the operand signs differ,
its top bit is replaced so that the top bit alone gives the ordering. Add and reverse
subtract can take their carry-in from the stored carry bit. A keep control lets an
instruction use the carry without updating it. A preset port lets the environment
load both carry bits directly.

Top module: `addsub_cmp_unit`

## Requirements
- R1: With `op_i`=0 (add), `result_o` = A + B + cin modulo 2^32, where cin is the stored carry when `use_carry_i`=1 and 0 otherwise.
- R2: With `op_i`=1 (reverse subtract), `result_o` = B + ~A + cin modulo 2^32, where cin is the stored carry when `use_carry_i`=1 and 1 otherwise.
- R3: The carry-out of an add or reverse subtract is bit 32 of the 33-bit sum of its two addends and cin. This bit is loaded into both `carry_o` and `carry_copy_o` on the rising edge when `en_i`=1 and `keep_carry_i`=0.
- R4: When `keep_carry_i`=1, an enabled add or reverse subtract leaves both carry bits unchanged.
- R5: With `op_i`=2 (signed compare), `result_o` is B + ~A + 1. When A[31] differs from B[31], bit 31 is replaced by B[31].
- R6: With `op_i`=3 (unsigned compare), `result_o` is B + ~A + 1. When A[31] differs from B[31], bit 31 is replaced by A[31].
- R7: A compare never changes either carry bit, and its result does not depend on `use_carry_i` or on the stored carry.
- R8: With `en_i`=0 and `preset_we_i`=0, both carry bits hold their value.
- R9: While `rst_ni` is low, both carry bits are 0.
- R10: With `preset_we_i`=1, both carry bits take `preset_val_i` on the next rising edge. This holds even when an enabled, non-keep add or subtract falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Operation strobe; permits a carry update |
| op_i | input | 2 | 0 add, 1 reverse subtract, 2 signed compare, 3 unsigned compare |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| use_carry_i | input | 1 | Take carry-in from the stored carry bit |
| keep_carry_i | input | 1 | Suppress the carry update |
| preset_we_i | input | 1 | Load both carry bits from `preset_val_i` |
| preset_val_i | input | 1 | Value for the carry preset |
| result_o | output | 32 | Combinational result |
| carry_o | output | 1 | Stored carry bit |
| carry_copy_o | output | 1 | Stored carry copy bit |

## Verification
The preset write and the arithmetic carry update can both target the carry bits in the same cycle. The bench provokes this with an enabled add whose carry-out is 1 while it presets the carry to 0. It then reads the carry bits one edge later and expects the preset value. The bench also sets `use_carry_i` during compares with the stored carry both set and clear, and expects the result and the flags to stay the same.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_RSUB = 2'd1,
    OP_CMPS = 2'd2,
    OP_CMPU = 2'd3
  } alu_op_e;
endpackage

// File: rtl/alu_cin_sel.sv
`timescale 1ns/1ps
module alu_cin_sel
  import alu_pkg::*;
(
  input  alu_op_e op_i,
  input  logic    use_carry_i,
  input  logic    carry_q_i,
  output logic    cin_o
);
  always_comb begin
    unique case (op_i)
      OP_ADD:  cin_o = use_carry_i ? carry_q_i : 1'b0;
      OP_RSUB: cin_o = use_carry_i ? carry_q_i : 1'b1;
      default: cin_o = 1'b1;  // compares always form B - A
    endcase
  end
endmodule

// File: rtl/alu_adder.sv
`timescale 1ns/1ps
module alu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] ext;
  assign ext    = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
  assign sum_o  = ext[W-1:0];
  assign cout_o = ext[W];
endmodule

// File: rtl/alu_cmp_fix.sv
`timescale 1ns/1ps
module alu_cmp_fix
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op_i,
  input  logic         a_msb_i,
  input  logic         b_msb_i,
  input  logic [W-1:0] sum_i,
  output logic [W-1:0] result_o
);
  logic is_cmp, sign_diff, fix_bit;
  assign is_cmp    = (op_i == OP_CMPS) || (op_i == OP_CMPU);
  assign sign_diff = a_msb_i ^ b_msb_i;
  assign fix_bit   = (op_i == OP_CMPS) ? b_msb_i : a_msb_i;

  always_comb begin
    result_o = sum_i;
    if (is_cmp && sign_diff) result_o[W-1] = fix_bit;
  end
endmodule

// File: rtl/alu_flag_reg.sv
`timescale 1ns/1ps
module alu_flag_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic preset_we_i,
  input  logic preset_val_i,
  input  logic upd_i,
  input  logic cout_i,
  output logic carry_o,
  output logic carry_copy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_o      <= 1'b0;
      carry_copy_o <= 1'b0;
    end else if (preset_we_i) begin  // preset wins over update
      carry_o      <= preset_val_i;
      carry_copy_o <= preset_val_i;
    end else if (upd_i) begin
      carry_o      <= cout_i;
      carry_copy_o <= cout_i;
    end
  end
endmodule

// File: rtl/addsub_cmp_unit.sv
`timescale 1ns/1ps
module addsub_cmp_unit
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         use_carry_i,
  input  logic         keep_carry_i,
  input  logic         preset_we_i,
  input  logic         preset_val_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         carry_copy_o
);
  alu_op_e      op;
  logic [W-1:0] x, y, sum;
  logic         cin, cout, is_arith, upd;

  assign op       = alu_op_e'(op_i);
  assign is_arith = (op == OP_ADD) || (op == OP_RSUB);
  assign x        = (op == OP_ADD) ? a_i : b_i;
  assign y        = (op == OP_ADD) ? b_i : ~a_i;
  assign upd      = en_i && !keep_carry_i && is_arith;

  alu_cin_sel u_cin (
    .op_i(op), .use_carry_i(use_carry_i), .carry_q_i(carry_o), .cin_o(cin)
  );

  alu_adder #(.W(W)) u_add (
    .x_i(x), .y_i(y), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  alu_cmp_fix #(.W(W)) u_fix (
    .op_i(op), .a_msb_i(a_i[W-1]), .b_msb_i(b_i[W-1]),
    .sum_i(sum), .result_o(result_o)
  );

  alu_flag_reg u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .preset_we_i(preset_we_i), .preset_val_i(preset_val_i),
    .upd_i(upd), .cout_i(cout),
    .carry_o(carry_o), .carry_copy_o(carry_copy_o)
  );
endmodule

// File: rtl/addsub_cmp_unit_chk.sv
`timescale 1ns/1ps
module addsub_cmp_unit_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic [1:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         use_carry_i,
  input logic         keep_carry_i,
  input logic         preset_we_i,
  input logic         preset_val_i,
  input logic [W-1:0] result_o,
  input logic         carry_o,
  input logic         carry_copy_o
);
  assert_add_plain_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'd0 && !use_carry_i) |-> result_o == W'(a_i + b_i));

  assert_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && keep_carry_i && !preset_we_i) |=> ($stable(carry_o) && $stable(carry_copy_o)));

  assert_scmp_msb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'd2 && (a_i[W-1] != b_i[W-1])) |-> result_o[W-1] == b_i[W-1]);

  assert_ucmp_msb_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'd3 && (a_i[W-1] != b_i[W-1])) |-> result_o[W-1] == a_i[W-1]);

  assert_cmp_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[1] && !preset_we_i) |=> ($stable(carry_o) && $stable(carry_copy_o)));

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !preset_we_i) |=> ($stable(carry_o) && $stable(carry_copy_o)));

  assert_preset_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_we_i |=> (carry_o == $past(preset_val_i) && carry_copy_o == $past(preset_val_i)));
endmodule

bind addsub_cmp_unit addsub_cmp_unit_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
  .use_carry_i(use_carry_i), .keep_carry_i(keep_carry_i),
  .preset_we_i(preset_we_i), .preset_val_i(preset_val_i),
  .result_o(result_o), .carry_o(carry_o), .carry_copy_o(carry_copy_o)
);

// File: tb/sim_addsub_cmp_unit.sv
`timescale 1ns/1ps
module sim_addsub_cmp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [31:0] a = '0, b = '0;
  logic        uc = 1'b0, kc = 1'b0, pwe = 1'b0, pval = 1'b0;
  logic [31:0] res;
  logic        c, cc;
  int          errors = 0, checks = 0;
  logic        exp_c = 1'b0;
  bit          done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  addsub_cmp_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .op_i(op), .a_i(a), .b_i(b),
    .use_carry_i(uc), .keep_carry_i(kc), .preset_we_i(pwe), .preset_val_i(pval),
    .result_o(res), .carry_o(c), .carry_copy_o(cc)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation: result checked before the edge, flags after it
  task automatic run_op(string req, logic [1:0] o, logic [31:0] va, logic [31:0] vb,
                        logic vuc, logic vkc, logic ven, logic vpwe, logic vpval);
    logic [32:0] s;
    logic [31:0] er;
    logic        cin;
    @(negedge clk);
    op = o; a = va; b = vb; uc = vuc; kc = vkc; en = ven; pwe = vpwe; pval = vpval;
    if (o == 2'd0) cin = vuc ? exp_c : 1'b0;
    else if (o == 2'd1) cin = vuc ? exp_c : 1'b1;
    else cin = 1'b1;
    if (o == 2'd0) s = {1'b0, va} + {1'b0, vb} + 33'(cin);
    else s = {1'b0, vb} + {1'b0, ~va} + 33'(cin);
    er = s[31:0];
    if (o == 2'd2 && va[31] != vb[31]) er[31] = vb[31];
    if (o == 2'd3 && va[31] != vb[31]) er[31] = va[31];
    #1 check({req, " result"}, res, er);
    if (vpwe) exp_c = vpval;
    else if (ven && !vkc && !o[1]) exp_c = s[32];
    @(negedge clk);
    en = 1'b0; pwe = 1'b0;
    check({req, " carry"}, {31'd0, c}, {31'd0, exp_c});
    check({req, " carry copy"}, {31'd0, cc}, {31'd0, exp_c});
  endtask

  task automatic preset(logic v);
    run_op("R10 preset", 2'd2, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b1, v);
  endtask

  task automatic t_reset;
    check("R9 carry at reset", {31'd0, c}, 32'd0);
    check("R9 copy at reset", {31'd0, cc}, 32'd0);
  endtask

  task automatic t_add;
    run_op("R1 add small", 2'd0, 32'd5, 32'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    run_op("R3 add wrap", 2'd0, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    run_op("R1 add with carry", 2'd0, 32'd1, 32'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    preset(1'b1);
    run_op("R3 add B all ones plus carry", 2'd0, 32'd0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_rsub;
    preset(1'b0);
    run_op("R2 rsub no borrow", 2'd1, 32'd3, 32'd10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    run_op("R2 rsub borrow", 2'd1, 32'd10, 32'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    run_op("R2 rsub carry in zero", 2'd1, 32'd3, 32'd10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_cmps;
    run_op("R5 scmp b neg", 2'd2, 32'd1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    run_op("R5 scmp a neg", 2'd2, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    run_op("R5 scmp same sign", 2'd2, 32'd5, 32'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_cmpu;
    run_op("R6 ucmp b high", 2'd3, 32'd1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    run_op("R6 ucmp a high", 2'd3, 32'h8000_0000, 32'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_cmp_flags;
    preset(1'b1);
    run_op("R7 cmp keeps carry 1", 2'd3, 32'd9, 32'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R7 ucmp value", res, 32'hFFFF_FFF9);
    preset(1'b0);
    run_op("R7 cmp keeps carry 0", 2'd2, 32'd2, 32'd9, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R7 scmp value", res, 32'd7);
  endtask

  task automatic t_keep;
    preset(1'b0);
    run_op("R4 keep add", 2'd0, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R4 carry held", {31'd0, c}, 32'd0);
  endtask

  task automatic t_idle;
    run_op("R8 idle add", 2'd0, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 carry held", {31'd0, c}, 32'd0);
  endtask

  task automatic t_collide;
    run_op("R10 preset vs update", 2'd0, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R10 preset wins", {31'd0, c}, 32'd0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_add();
    t_rsub();
    t_cmps();
    t_cmpu();
    t_cmp_flags();
    t_keep();
    t_idle();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule